// File: doc/BRIEF.md
# Serial Flash Status-Register Write Controller

This block is the slave-side command logic of a serial flash device for the three commands that deal with the status register. These commands set the write-enable latch, write the status register and read the status register. The chip select, serial clock, serial data and write-protect pins are synchronised into the system clock domain, and the block works in SPI mode 0. Data enters MSB first on rising serial-clock edges, and data leaves MSB first after falling edges.

A status write is committed only when the frame is an 8-bit opcode followed by exactly one data byte, and only when the enable latch is already set. The commit starts a self-timed internal cycle of `WR_CYCLES` system clocks. The block reports the cycle as busy in status bit 0 until it ends. When the cycle ends, the enable latch clears. The protect-lock bit (bit 7) combined with a low write-protect pin blocks status writes.

A separate active-low device reset pin aborts command framing and clears the enable latch. If that pin is asserted while an internal cycle is running, the cycle is allowed to finish first.

Top module: `spi_status_ctrl`

## Requirements
- R1: A frame holding opcode 0x06 and exactly 8 bits, with the busy bit at 0, sets the enable latch (status bit 1) when chip select rises.
- R2: A frame holding opcode 0x01 and one data byte (exactly 16 bits), with the enable latch set, writes data bit 7 to status bit 7 and data bits 4:2 to status bits 4:2. Status bits 6 and 5 always read 0, and data bits 6, 5, 1 and 0 have no effect.
- R3: A status-write frame sent while the enable latch is 0 changes nothing.
- R4: A status-write frame of 15 or 17 bits is discarded, and the enable latch stays set.
- R5: The busy bit (status bit 0) reads 1 from the commit for `WR_CYCLES` clocks and can be read during that time. After the cycle the busy bit reads 0 and the enable latch is cleared.
- R6: When status bit 7 is 1 and wp_ni is low, a status write is ignored and the enable latch stays set. With wp_ni high, the same write executes.
- R7: Opcode 0x05 streams the status byte MSB first, repeating it for as long as chip select stays low. sdo_o changes after falling serial-clock edges.
- R8: sdo_oe_o is 1 only while status data is being shifted out in a selected frame.
- R9: Enable and status-write commands received while the busy bit is 1 are ignored.
- R10: After an unknown opcode, the rest of the frame is ignored, even if it contains a valid opcode.
- R11: A low dev_rst_ni during the internal cycle does not shorten the cycle, and the write completes. While dev_rst_ni is low and the block is not busy, commands are ignored and the enable latch is cleared. Bits 7 and 4:2 are retained.
- R12: Asserting rst_ni asynchronously sets the whole status byte to 0x00 and drives sdo_oe_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| dev_rst_ni | input | 1 | Device reset pin, active low |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock (mode 0) |
| sdi_i | input | 1 | Serial data in |
| wp_ni | input | 1 | Write-protect pin, active low |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for sdo_o; low means high impedance |

## Verification
The bench targets frame-length boundaries. A design that commits on 15 or 17 bits would corrupt the protect bits, and one that drops the enable latch on a bad frame would block the retry. It also sends commands during the busy window. A design that accepts them would restart or overwrite the cycle, and one that loses the busy bit early would report completion too soon.

The lock-bit and write-protect combination is covered in both pin states, along with an unknown opcode followed by a valid one in the same frame. A device reset pulse arrives mid-cycle. A design that cut the cycle short would leave the old protect bits, and one that ignored the pending reset would accept commands while the pin is held low.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_RDSR = 8'h05;

  localparam int unsigned OP_BITS    = 8;
  localparam int unsigned FRAME_BITS = 16;

  typedef struct packed {
    logic       srwd;
    logic [2:0] bp;
    logic       wel;
    logic       wip;
  } stat_t;

  function automatic logic [7:0] stat_byte(input stat_t s);
    return {s.srwd, 2'b00, s.bp, s.wel, s.wip};
  endfunction
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic sdi_i,
  input  logic wp_ni,
  input  logic dev_rst_ni,
  output logic cs_n_o,
  output logic cs_rise_o,
  output logic cs_fall_o,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic sdi_o,
  output logic wp_n_o,
  output logic dev_rst_n_o
);
  localparam int unsigned NSIG = 5;
  // bit order: dev_rst, wp, sdi, sck, cs
  localparam logic [NSIG-1:0] RST_VAL = 5'b11001;

  logic [NSIG-1:0] raw;
  logic [STAGES-1:0][NSIG-1:0] pipe_q;
  logic cs_prev_q, sck_prev_q;
  logic [NSIG-1:0] synced;

  assign raw    = {dev_rst_ni, wp_ni, sdi_i, sck_i, cs_ni};
  assign synced = pipe_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(STAGES); i++) pipe_q[i] <= RST_VAL;
      cs_prev_q  <= 1'b1;
      sck_prev_q <= 1'b0;
    end else begin
      pipe_q[0] <= raw;
      for (int i = 1; i < int'(STAGES); i++) pipe_q[i] <= pipe_q[i-1];
      cs_prev_q  <= synced[0];
      sck_prev_q <= synced[1];
    end
  end

  assign cs_n_o      = synced[0];
  assign sdi_o       = synced[2];
  assign wp_n_o      = synced[3];
  assign dev_rst_n_o = synced[4];
  assign cs_rise_o   = synced[0] & ~cs_prev_q;
  assign cs_fall_o   = ~synced[0] & cs_prev_q;
  assign sck_rise_o  = synced[1] & ~sck_prev_q;
  assign sck_fall_o  = ~synced[1] & sck_prev_q;
endmodule

// File: rtl/spi_cmd_frame.sv
module spi_cmd_frame #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_n_i,
  input  logic             cs_fall_i,
  input  logic             sck_rise_i,
  input  logic             sdi_i,
  input  logic             abort_i,
  output logic [7:0]       opcode_o,
  output logic [7:0]       data_o,
  output logic [CNT_W-1:0] bit_cnt_o,
  output logic             dead_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [7:0]       sh_q, op_q;
  logic [CNT_W-1:0] cnt_q;
  logic             dead_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      op_q   <= '0;
      cnt_q  <= '0;
      dead_q <= 1'b0;
    end else if (cs_fall_i) begin
      sh_q   <= '0;
      op_q   <= '0;
      cnt_q  <= '0;
      dead_q <= abort_i;
    end else begin
      if (abort_i) dead_q <= 1'b1;
      if (sck_rise_i && !cs_n_i && !dead_q) begin
        sh_q <= {sh_q[6:0], sdi_i};
        if (cnt_q == CNT_W'(7)) op_q <= {sh_q[6:0], sdi_i};
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign opcode_o  = op_q;
  assign data_o    = sh_q;
  assign bit_cnt_o = cnt_q;
  assign dead_o    = dead_q;

  AST_CNT_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cnt_q) == CNT_MAX && !$past(cs_fall_i)) |-> cnt_q == CNT_MAX); // R4
endmodule

// File: rtl/spi_stat_core.sv
module spi_stat_core
  import spi_stat_pkg::*;
#(
  parameter int unsigned WR_CYCLES = 1000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wren_go_i,
  input  logic       wrsr_go_i,
  input  logic [7:0] wr_data_i,
  input  logic       dev_rst_n_i,
  input  logic       wp_n_i,
  output stat_t      stat_o,
  output logic       in_reset_o
);
  localparam int unsigned TW = $clog2(WR_CYCLES + 1);

  logic          srwd_q, wel_q, wip_q, rst_pend_q;
  logic [2:0]    bp_q;
  logic [TW-1:0] tmr_q;
  logic          done;

  assign done       = wip_q && (tmr_q == TW'(1));
  // a reset seen during the cycle waits for the cycle to finish
  assign in_reset_o = (rst_pend_q || !dev_rst_n_i) && !wip_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      srwd_q     <= 1'b0;
      bp_q       <= '0;
      wel_q      <= 1'b0;
      wip_q      <= 1'b0;
      tmr_q      <= '0;
      rst_pend_q <= 1'b0;
    end else begin
      if (!dev_rst_n_i)  rst_pend_q <= 1'b1;
      else if (!wip_q)   rst_pend_q <= 1'b0;

      if (in_reset_o || done) wel_q <= 1'b0;
      else if (wren_go_i)     wel_q <= 1'b1;

      if (wrsr_go_i) begin
        srwd_q <= wr_data_i[7];
        bp_q   <= wr_data_i[4:2];
        wip_q  <= 1'b1;
        tmr_q  <= TW'(WR_CYCLES);
      end else if (wip_q) begin
        tmr_q <= tmr_q - 1'b1;
        if (done) wip_q <= 1'b0;
      end
    end
  end

  assign stat_o = '{srwd: srwd_q, bp: bp_q, wel: wel_q, wip: wip_q};

  AST_WRSR_NEEDS_WEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wip_q) |-> $past(wel_q)); // R3
  AST_WRSR_PROTECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wip_q) |-> !($past(srwd_q) && !$past(wp_n_i))); // R6
  AST_WEL_CLR_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wip_q) |-> !wel_q); // R5
  AST_BUSY_NO_WEL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wel_q) |-> !$past(wip_q)); // R9
  AST_CYCLE_NOT_CUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wip_q && !dev_rst_n_i && tmr_q != TW'(1)) |=> wip_q); // R11
endmodule

// File: rtl/spi_sdo_shift.sv
module spi_sdo_shift (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_n_i,
  input  logic       sck_fall_i,
  input  logic       arm_i,
  input  logic       abort_i,
  input  logic [7:0] stat_i,
  output logic       sdo_o,
  output logic       sdo_oe_o
);
  logic [7:0] sh_q;
  logic [2:0] idx_q;
  logic       act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      idx_q <= '0;
      act_q <= 1'b0;
    end else if (cs_n_i || abort_i) begin
      act_q <= 1'b0;
      idx_q <= '0;
    end else if (sck_fall_i) begin
      if (!act_q) begin
        if (arm_i) begin
          act_q <= 1'b1;
          sh_q  <= stat_i;
          idx_q <= 3'd7;
        end
      end else if (idx_q == 3'd0) begin
        // byte done: reload the live status value
        sh_q  <= stat_i;
        idx_q <= 3'd7;
      end else begin
        sh_q  <= {sh_q[6:0], 1'b0};
        idx_q <= idx_q - 1'b1;
      end
    end
  end

  assign sdo_o    = act_q & sh_q[7];
  assign sdo_oe_o = act_q;

  AST_OE_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdo_oe_o |-> !$past(cs_n_i)); // R8
endmodule

// File: rtl/spi_status_ctrl.sv
module spi_status_ctrl
  import spi_stat_pkg::*;
#(
  parameter int unsigned WR_CYCLES   = 1000,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CNT_W       = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dev_rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic sdi_i,
  input  logic wp_ni,
  output logic sdo_o,
  output logic sdo_oe_o
);
  logic cs_n, cs_rise, cs_fall, sck_rise, sck_fall, sdi, wp_n, dev_rst_n;
  logic [7:0]       opcode, data;
  logic [CNT_W-1:0] bit_cnt;
  logic             dead, in_reset;
  logic             wren_go, wrsr_go, rd_arm, locked;
  stat_t            stat;

  spi_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .cs_ni, .sck_i, .sdi_i, .wp_ni, .dev_rst_ni,
    .cs_n_o(cs_n), .cs_rise_o(cs_rise), .cs_fall_o(cs_fall),
    .sck_rise_o(sck_rise), .sck_fall_o(sck_fall), .sdi_o(sdi),
    .wp_n_o(wp_n), .dev_rst_n_o(dev_rst_n)
  );

  spi_cmd_frame #(.CNT_W(CNT_W)) u_frame (
    .clk_i, .rst_ni, .cs_n_i(cs_n), .cs_fall_i(cs_fall),
    .sck_rise_i(sck_rise), .sdi_i(sdi), .abort_i(in_reset),
    .opcode_o(opcode), .data_o(data), .bit_cnt_o(bit_cnt), .dead_o(dead)
  );

  assign locked  = stat.srwd && !wp_n;
  assign wren_go = cs_rise && !dead && !in_reset && !stat.wip &&
                   opcode == OP_WREN && bit_cnt == CNT_W'(OP_BITS);
  assign wrsr_go = cs_rise && !dead && !in_reset && !stat.wip && stat.wel &&
                   !locked && opcode == OP_WRSR && bit_cnt == CNT_W'(FRAME_BITS);
  assign rd_arm  = !dead && opcode == OP_RDSR && bit_cnt == CNT_W'(OP_BITS);

  spi_stat_core #(.WR_CYCLES(WR_CYCLES)) u_core (
    .clk_i, .rst_ni, .wren_go_i(wren_go), .wrsr_go_i(wrsr_go),
    .wr_data_i(data), .dev_rst_n_i(dev_rst_n), .wp_n_i(wp_n),
    .stat_o(stat), .in_reset_o(in_reset)
  );

  spi_sdo_shift u_sdo (
    .clk_i, .rst_ni, .cs_n_i(cs_n), .sck_fall_i(sck_fall), .arm_i(rd_arm),
    .abort_i(in_reset), .stat_i(stat_byte(stat)),
    .sdo_o, .sdo_oe_o
  );
endmodule

// File: tb/spi_status_ctrl_tb.sv
module spi_status_ctrl_tb;
  localparam int WR   = 600;
  localparam int HALF = 6;

  logic clk_i = 1'b0, rst_ni = 1'b0, dev_rst_ni = 1'b1;
  logic cs_ni = 1'b1, sck_i = 1'b0, sdi_i = 1'b0, wp_ni = 1'b1;
  logic sdo_o, sdo_oe_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct { logic [7:0] v; string tag; } item_t;
  item_t exp_q[$];
  logic [7:0] got_q[$];

  always #10 clk_i = ~clk_i;

  spi_status_ctrl #(.WR_CYCLES(WR)) u_dut (.*);

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (got_q.size() > 0 && exp_q.size() > 0) begin
      item_t e;
      logic [7:0] g;
      e = exp_q.pop_front();
      g = got_q.pop_front();
      chk(g, e.v, e.tag);
    end
  end

  task automatic xbit(input logic b, output logic q, output logic oe);
    sdi_i = b;
    repeat (HALF) @(negedge clk_i);
    sck_i = 1'b1;
    q  = sdo_o;
    oe = sdo_oe_o;
    repeat (HALF) @(negedge clk_i);
    sck_i = 1'b0;
  endtask

  task automatic frame(input logic [31:0] v, input int n);
    logic q, oe;
    @(negedge clk_i);
    cs_ni = 1'b0;
    repeat (HALF) @(negedge clk_i);
    for (int i = n - 1; i >= 0; i--) xbit(v[i], q, oe);
    repeat (HALF) @(negedge clk_i);
    cs_ni = 1'b1;
    repeat (10) @(negedge clk_i);
  endtask

  // driver: pushes expectation, captures bytes for the monitor
  task automatic rdsr(input int nbytes, input logic [7:0] expv, input string tag);
    logic q, oe;
    logic [7:0] b;
    @(negedge clk_i);
    cs_ni = 1'b0;
    repeat (HALF) @(negedge clk_i);
    for (int i = 7; i >= 0; i--) xbit(spi_stat_pkg::OP_RDSR[i], q, oe);
    for (int k = 0; k < nbytes; k++) begin
      for (int i = 7; i >= 0; i--) begin
        xbit(1'b0, q, oe);
        b[i] = q;
        if (k == 0 && i == 7) chk({7'd0, oe}, 8'd1, "R8 oe during read");
      end
      exp_q.push_back('{v: expv, tag: tag});
      got_q.push_back(b);
    end
    repeat (HALF) @(negedge clk_i);
    cs_ni = 1'b1;
    repeat (10) @(negedge clk_i);
    chk({7'd0, sdo_oe_o}, 8'd0, "R8 oe after read");
  endtask

  task automatic wait_cycle();
    repeat (WR + 100) @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk({7'd0, sdo_oe_o}, 8'd0, "R12 oe in reset");
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    rdsr(1, 8'h00, "R12 reset status");

    frame(32'h06, 8);
    rdsr(1, 8'h02, "R1 wren sets latch");

    frame(32'h01FF, 16);
    rdsr(1, 8'h9F, "R5 busy readable / R2 write");
    frame(32'h0100, 16);          // busy: must be ignored
    frame(32'h06, 8);
    wait_cycle();
    rdsr(1, 8'h9C, "R9 busy ignored / R5 latch cleared / R2 mask");

    wp_ni = 1'b0;
    frame(32'h06, 8);
    frame(32'h0100, 16);
    rdsr(1, 8'h9E, "R6 locked write ignored");
    wp_ni = 1'b1;
    frame(32'h0100, 16);
    wait_cycle();
    rdsr(1, 8'h00, "R6 unlocked write executes");

    frame(32'h011C, 16);
    wait_cycle();
    rdsr(1, 8'h00, "R3 no latch no write");

    frame(32'hFF06, 16);
    rdsr(1, 8'h00, "R10 unknown opcode poisons frame");

    frame(32'h06, 8);
    frame(32'h0100 >> 1, 15);
    rdsr(1, 8'h02, "R4 short frame discarded");
    frame(32'h01FF << 1, 17);
    wait_cycle();
    rdsr(1, 8'h02, "R4 long frame discarded");

    rdsr(3, 8'h02, "R7 repeated stream");

    frame(32'h0174, 16);
    wait_cycle();
    rdsr(1, 8'h14, "R2 bits 6 5 ignored");

    frame(32'h06, 8);
    frame(32'h0108, 16);
    repeat (20) @(negedge clk_i);
    dev_rst_ni = 1'b0;
    rdsr(1, 8'h0B, "R11 cycle continues under reset");
    wait_cycle();
    frame(32'h06, 8);             // held in reset: ignored
    dev_rst_ni = 1'b1;
    repeat (10) @(negedge clk_i);
    rdsr(1, 8'h08, "R11 write done latch clear");
    frame(32'h06, 8);
    rdsr(1, 8'h0A, "R11 commands resume");

    repeat (20) @(negedge clk_i);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule